// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is a serial bus master that keeps an external sampling converter running without processor help. Each round begins with a 16-bit frame. During the frame the block shifts a control word out on its data-out line. That word tells the converter to start a new conversion. In the same frame the block shifts in the result of the conversion that the previous frame started. The serial clock idles high. The block changes data-out on each falling serial edge and samples data-in on each rising serial edge.

Between frames the block waits for the converter to finish. Completion is seen as a falling edge on the converter's busy output, after that signal passes through a synchroniser. If that edge does not come within a programmable number of system cycles, the block flags a timeout and moves on. Two options change the round. One skips the wait entirely, so frames run back to back. The other keeps data-out at zero, so the converter only gets reads. Each captured word is shown on a result port with a one-cycle valid strobe and stays there until the next frame completes. The word from the very first frame after reset is not strobed, because no conversion came before it.

Top module: `adc_seq_master`

## Requirements
- R1: During reset, sclk and fs_n are 1, and sdo, res_valid and timeout are 0.
- R2: A frame holds fs_n low for 33 serial half periods. These are one lead half period with sclk high, then 16 low/high sclk pairs. Outside a frame, sclk stays high.
- R3: A serial half period lasts clk_div+1 system clock cycles. The first falling sclk edge comes one half period after fs_n falls.
- R4: sdo carries ctrl_word MSB first. Bit 15 appears at the first falling sclk edge, and each later bit appears at the next falling edge. sdo is 0 outside a frame.
- R5: sdi is sampled at each rising sclk edge, MSB first. The 16-bit word appears on res_data in the cycle after fs_n rises. res_valid is high for that one cycle, and res_data holds until the next frame ends.
- R6: The first frame after reset updates res_data but does not raise res_valid.
- R7: In wait mode (skip_busy=0), suppose busy is sampled 1 at one clock edge and 0 at the next edge E, while the block is waiting. Then fs_n falls SYNC_STAGES+1 edges after E if enable is 1.
- R8: If no busy fall is seen during tmo_limit+1 waiting cycles, timeout pulses for one cycle. A new frame starts one cycle later if enable is 1.
- R9: With skip_busy=1, the next frame starts two edges after fs_n rises, whatever busy does.
- R10: With read_only=1 when a frame starts, sdo stays 0 for that whole frame.
- R11: With enable=0, no new frame starts. A frame already in progress still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allow new frames to start |
| ctrl_word | input | FRAME_W | Control word sent in each frame |
| clk_div | input | DIV_W | Serial half period minus one, in system cycles |
| tmo_limit | input | TMO_W | Completion timeout, waiting cycles minus one |
| skip_busy | input | 1 | 1: start the next frame without waiting on busy |
| read_only | input | 1 | 1: hold sdo at 0 for the frame |
| busy | input | 1 | Converter busy, asynchronous |
| sdi | input | 1 | Serial data from converter |
| sclk | output | 1 | Gated serial clock, idles high |
| fs_n | output | 1 | Frame select, active low |
| sdo | output | 1 | Serial data to converter |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | FRAME_W | Most recent captured word |
| timeout | output | 1 | One-cycle pulse when the wait timed out |

## Verification
The hardest case to reach from the ports is a busy fall that comes outside the waiting window. This happens when a conversion outlasts the timeout, so busy drops while the next frame is already shifting. That fall must not end the following wait early. A bench converter responder watches fs_n and drives busy with a programmable delay and length. One phase stretches the conversion past a short timeout to line up exactly this overlap. A behavioural model recomputes every output from a history queue of sampled busy values.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_LEAD,
      SQ_LOW,
      SQ_HIGH,
      SQ_WAIT
   } sq_state_t;

endpackage

// File: rtl/adc_seq_sync.sv
// Multi-stage synchroniser for the busy line with a registered fall detector.
module adc_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic fell
);

   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("adc_seq_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], din};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[STAGES-1];
   end

   assign level = chain[STAGES-1];
   assign fell  = prev & ~chain[STAGES-1];

endmodule

// File: rtl/adc_seq_divider.sv
// Half-period tick generator; counts only while a frame is active.
module adc_seq_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] limit,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;
   logic             at_end;

   assign at_end = (cnt == limit);
   assign tick   = run & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (at_end) cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/adc_seq_shreg.sv
// Transmit and receive shift registers, MSB first.
module adc_seq_shreg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_word,
   input  logic         shift_tx,
   input  logic         shift_rx,
   input  logic         sdi,
   output logic         tx_msb,
   output logic [W-1:0] rx_word
);

   logic [W-1:0] tx_q;
   logic [W-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tx_q <= '0;
      else if (load)     tx_q <= load_word;
      else if (shift_tx) tx_q <= {tx_q[W-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rx_q <= '0;
      else if (shift_rx) rx_q <= {rx_q[W-2:0], sdi};
   end

   assign tx_msb  = tx_q[W-1];
   assign rx_word = rx_q;

endmodule

// File: rtl/adc_seq_waiter.sv
// Decides when the inter-frame wait ends: skip, busy fall or timeout.
module adc_seq_waiter #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             skip,
   input  logic             busy_fell,
   input  logic [TMO_W-1:0] limit,
   output logic             done,
   output logic             expired
);

   logic [TMO_W-1:0] cnt;
   logic             at_limit;

   assign at_limit = (cnt == limit);
   assign expired  = active & ~skip & ~busy_fell & at_limit;
   assign done     = active & (skip | busy_fell | at_limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!active) cnt <= '0;
      else if (!done)   cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/adc_seq_master.sv
module adc_seq_master
   import adc_seq_pkg::*;
#(
   parameter int FRAME_W     = 16,
   parameter int DIV_W       = 8,
   parameter int TMO_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [FRAME_W-1:0] ctrl_word,
   input  logic [DIV_W-1:0]   clk_div,
   input  logic [TMO_W-1:0]   tmo_limit,
   input  logic               skip_busy,
   input  logic               read_only,
   input  logic               busy,
   input  logic               sdi,
   output logic               sclk,
   output logic               fs_n,
   output logic               sdo,
   output logic               res_valid,
   output logic [FRAME_W-1:0] res_data,
   output logic               timeout
);

   localparam int BIT_W = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("adc_seq_master: FRAME_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("adc_seq_master: DIV_W must be at least 1");
      end
      if (TMO_W < 1) begin : g_bad_tmo
         $error("adc_seq_master: TMO_W must be at least 1");
      end
   endgenerate

   sq_state_t        state;
   logic [BIT_W-1:0] bit_cnt;
   logic             first_q;
   logic             tick;
   logic             in_frame;
   logic             last_bit;
   logic             start;
   logic             busy_lvl;
   logic             busy_fell;
   logic             wait_done;
   logic             wait_tmo;
   logic             tx_msb;
   logic [FRAME_W-1:0] rx_word;
   logic             shift_tx;
   logic             shift_rx;

   assign in_frame = (state == SQ_LEAD) || (state == SQ_LOW) || (state == SQ_HIGH);
   assign last_bit = (bit_cnt == LAST_BIT);
   assign start    = (state == SQ_IDLE) && enable;
   assign shift_tx = tick && ((state == SQ_LEAD) || ((state == SQ_HIGH) && !last_bit));
   assign shift_rx = tick && (state == SQ_LOW);

   adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (busy),
      .level (busy_lvl),
      .fell  (busy_fell)
   );

   adc_seq_divider #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (in_frame),
      .limit (clk_div),
      .tick  (tick)
   );

   adc_seq_shreg #(.W(FRAME_W)) u_shreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .load_word (read_only ? '0 : ctrl_word),
      .shift_tx  (shift_tx),
      .shift_rx  (shift_rx),
      .sdi       (sdi),
      .tx_msb    (tx_msb),
      .rx_word   (rx_word)
   );

   adc_seq_waiter #(.TMO_W(TMO_W)) u_wait (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (state == SQ_WAIT),
      .skip      (skip_busy),
      .busy_fell (busy_fell & ~busy_lvl),
      .limit     (tmo_limit),
      .done      (wait_done),
      .expired   (wait_tmo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         sclk      <= 1'b1;
         fs_n      <= 1'b1;
         sdo       <= 1'b0;
         bit_cnt   <= '0;
         first_q   <= 1'b1;
         res_valid <= 1'b0;
         res_data  <= '0;
         timeout   <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         timeout   <= wait_tmo;
         case (state)
            SQ_IDLE: begin
               if (enable) begin
                  state   <= SQ_LEAD;
                  fs_n    <= 1'b0;
                  bit_cnt <= '0;
               end
            end
            SQ_LEAD: begin
               if (tick) begin
                  state <= SQ_LOW;
                  sclk  <= 1'b0;
                  sdo   <= tx_msb;
               end
            end
            SQ_LOW: begin
               if (tick) begin
                  state <= SQ_HIGH;
                  sclk  <= 1'b1;
               end
            end
            SQ_HIGH: begin
               if (tick) begin
                  if (last_bit) begin
                     state     <= SQ_WAIT;
                     fs_n      <= 1'b1;
                     sdo       <= 1'b0;
                     res_data  <= rx_word;
                     res_valid <= ~first_q;
                     first_q   <= 1'b0;
                  end else begin
                     state   <= SQ_LOW;
                     sclk    <= 1'b0;
                     sdo     <= tx_msb;
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
            SQ_WAIT: begin
               if (wait_done) state <= SQ_IDLE;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
   input logic clk,
   input logic rst_n,
   input logic sclk,
   input logic fs_n,
   input logic sdo,
   input logic res_valid,
   input logic timeout
);

   // R2: serial clock parked high whenever no frame is selected
   assert_sclk_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fs_n |-> sclk);

   // R2: serial clock moves only inside a frame
   assert_sclk_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sclk) |-> !fs_n);

   // R4: data-out low between frames
   assert_sdo_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fs_n |-> !sdo);

   // R4: data-out changes only on a falling serial edge or at frame end
   assert_sdo_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo) |-> ($fell(sclk) || $rose(fs_n)));

   // R5: result strobe coincides with frame end and lasts one cycle
   assert_valid_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $rose(fs_n));
   assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R8: timeout is a single-cycle pulse outside any frame
   assert_tmo_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout);
   assert_tmo_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> fs_n);

endmodule

bind adc_seq_master adc_seq_checker chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .sclk      (sclk),
   .fs_n      (fs_n),
   .sdo       (sdo),
   .res_valid (res_valid),
   .timeout   (timeout)
);

// File: tb/adc_seq_master_tb.sv
module adc_seq_master_tb_top;

   localparam int SY = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [15:0] ctrl_word = '0;
   logic [7:0]  clk_div = '0;
   logic [15:0] tmo_limit = 16'd200;
   logic        skip_busy = 1'b0;
   logic        read_only = 1'b0;
   logic        busy = 1'b0;
   logic        sdi = 1'b0;
   logic        sclk, fs_n, sdo, res_valid, timeout;
   logic [15:0] res_data;

   always #2 clk = ~clk;

   adc_seq_master dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .ctrl_word(ctrl_word),
      .clk_div(clk_div), .tmo_limit(tmo_limit), .skip_busy(skip_busy),
      .read_only(read_only), .busy(busy), .sdi(sdi), .sclk(sclk), .fs_n(fs_n),
      .sdo(sdo), .res_valid(res_valid), .res_data(res_data), .timeout(timeout)
   );

   int vectors = 0;
   int errors  = 0;
   bit finished = 0;

   // responder configuration
   bit cnv_on = 1'b1;
   int cnv_len = 10;

   // reference model state
   logic [15:0] exp_q[$];
   int          mph = 0;
   int          t = 0, w = 0, hp = 1, nres = 0, cause = 0;
   logic [15:0] m_word = '0;
   logic        m_ro = 0;
   logic        first = 1;
   logic        hist[0:7];
   logic        e_sclk = 1, e_fs = 1, e_sdo = 0, e_valid = 0, e_tmo = 0;
   logic [15:0] e_data = '0;

   task automatic chk(string tag, string sig, logic [15:0] act, logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, sig, act, exp, $time);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   // behavioural model, advanced at every rising edge
   always @(posedge clk) begin
      e_valid = 0;
      e_tmo   = 0;
      if (!rst_n) begin
         mph = 0; e_sclk = 1; e_fs = 1; e_sdo = 0; e_data = '0; first = 1;
         for (int i = 0; i < 8; i++) hist[i] = 0;
      end else begin
         for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = busy;
         case (mph)
            0: if (enable) begin
                  mph = 1; t = 0; m_word = ctrl_word; m_ro = read_only;
                  hp = int'(clk_div) + 1; e_fs = 0;
               end
            1: begin
                  t++;
                  if (t == 33 * hp) begin
                     e_fs = 1; e_sclk = 1; e_sdo = 0; mph = 2; w = 0;
                     e_data = exp_q.pop_front();
                     e_valid = !first; first = 0; nres++;
                  end else if (t >= hp) begin
                     int k;
                     k = (t - hp) / hp;
                     e_sclk = (k % 2) != 0;
                     e_sdo = m_ro ? 1'b0 : m_word[15 - k/2];
                  end
               end
            default: begin
                  if (skip_busy) begin mph = 0; cause = 9; end
                  else if (hist[SY] == 0 && hist[SY+1] == 1) begin mph = 0; cause = 7; end
                  else if (w == int'(tmo_limit)) begin e_tmo = 1; mph = 0; cause = 8; end
                  else w++;
               end
         endcase
      end
   end

   // compare on every clock, away from the active edge
   initial forever begin
      string ftag;
      @(negedge clk);
      if (finished) break;
      if (!rst_n) begin
         chk("R1", "sclk", 16'(sclk), 16'(1'b1));
         chk("R1", "fs_n", 16'(fs_n), 16'(1'b1));
         chk("R1", "sdo", 16'(sdo), 16'(1'b0));
         chk("R1", "res_valid", 16'(res_valid), 16'(1'b0));
         chk("R1", "timeout", 16'(timeout), 16'(1'b0));
      end else begin
         if (mph == 1) ftag = "R2";
         else if (!enable) ftag = "R11";
         else if (cause == 7) ftag = "R7";
         else if (cause == 8) ftag = "R8";
         else if (cause == 9) ftag = "R9";
         else ftag = "R2";
         chk(ftag, "fs_n", 16'(fs_n), 16'(e_fs));
         chk("R3", "sclk", 16'(sclk), 16'(e_sclk));
         chk(m_ro ? "R10" : "R4", "sdo", 16'(sdo), 16'(e_sdo));
         chk(nres == 1 ? "R6" : "R5", "res_valid", 16'(res_valid), 16'(e_valid));
         chk("R5", "res_data", res_data, e_data);
         chk("R8", "timeout", 16'(timeout), 16'(e_tmo));
      end
   end

   // converter slave: launches result bits on falling serial edges
   initial begin
      logic        p_sclk, p_fs;
      logic [15:0] word;
      int          pos, nfr;
      p_sclk = 1; p_fs = 1; pos = 15; nfr = 0; word = '0;
      forever begin
         @(negedge clk);
         if (p_fs && !fs_n) begin
            word = 16'hA5C3 ^ 16'(nfr * 16'h1F35);
            nfr++;
            exp_q.push_back(word);
            pos = 15;
         end
         if (p_sclk && !sclk && !fs_n) begin
            sdi = word[pos];
            pos--;
         end
         p_sclk = sclk;
         p_fs = fs_n;
      end
   end

   // converter busy responder
   initial begin
      logic p_fs;
      int   cc;
      p_fs = 1; cc = -1;
      forever begin
         @(negedge clk);
         if (!p_fs && fs_n && cnv_on) cc = 0;
         else if (cc >= 0) cc++;
         if (cc >= 0) begin
            busy = (cc >= 2) && (cc < 2 + cnv_len);
            if (cc >= 2 + cnv_len) cc = -1;
         end else busy = 0;
         p_fs = fs_n;
      end
   end

   task automatic wait_frames(int n);
      int tgt;
      tgt = nres + n;
      while (nres < tgt) @(negedge clk);
   endtask

   task automatic at_gap();
      @(negedge clk);
      while (!fs_n) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         finished = 1;
         report();
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R3 R4 R5 R6 R7: busy-terminated rounds, fastest serial clock
      ctrl_word = 16'hC3A5; clk_div = 8'd0; cnv_on = 1; cnv_len = 10;
      enable = 1'b1;
      wait_frames(4);
      // R3: slower serial clock, other pattern
      at_gap(); clk_div = 8'd2; ctrl_word = 16'h5A0F;
      wait_frames(3);
      // R8: no busy activity, timeout paces the rounds
      at_gap(); cnv_on = 0; tmo_limit = 16'd25; clk_div = 8'd1;
      wait_frames(3);
      // R9: back-to-back frames
      at_gap(); cnv_on = 1; skip_busy = 1; ctrl_word = 16'h8001;
      wait_frames(3);
      // R10: read-only frames
      at_gap(); skip_busy = 0; read_only = 1; ctrl_word = 16'hFFFF; clk_div = 8'd3;
      wait_frames(3);
      // R7 R8: conversion outlasts timeout, busy falls during the next frame
      at_gap(); read_only = 0; ctrl_word = 16'h3C96; clk_div = 8'd1;
      cnv_len = 60; tmo_limit = 16'd30;
      wait_frames(4);
      // R11: drop enable mid-frame; frame completes, none follows
      @(negedge clk);
      while (fs_n) @(negedge clk);
      enable = 1'b0;
      repeat (300) @(negedge clk);
      chk("R11", "fs_n_idle", 16'(fs_n), 16'(1'b1));
      finished = 1;
      report();
   end

endmodule